// File: doc/BRIEF.md
# Highway and Farm-Road Crossing Light Controller

This block sequences the signals at a crossing where a busy highway meets a rarely used farm road. The highway shows green by default. A car sensor on the farm road asks for a turn. The highway is guaranteed a minimum green period before it yields. The farm road then gets a green that is capped in length and that ends early as soon as its sensor reports no car. Each direction passes through yellow on its way to red.

An interval timer is built into the block. It restarts whenever the controller changes phase. It reports a short expiry, which times the yellows, and a long expiry, which times the minimum highway green and the farm-road cap. Both expiry counts are parameters. The phase register can be built with any of three state codings, and all three behave identically at the ports. Each light output carries a fixed 2-bit colour code.

Top module: `tl_crossing_ctrl`

## Requirements
- R1: While `rst_n` is low, the highway lamp shows green (00), the farm lamp shows red (10) and `timer_start` is 0.
- R2: Highway green (farm red) is held unless the long expiry is present and `farm_car` is 1 in the same cycle. In that case the next cycle shows highway yellow (01).
- R3: Highway yellow (farm red) is held until the short expiry, then farm green (00) with highway red (10) follows.
- R4: Farm green is left for farm yellow (01, highway red) in the cycle after the long expiry is present or `farm_car` is 0.
- R5: Farm yellow is held until the short expiry, then highway green returns.
- R6: `timer_start` is 1 in exactly the first cycle of each new phase, and 0 in every other cycle.
- R7: The lamp codes are green 00, yellow 01 and red 10. At every moment at least one direction shows red.
- R8: The timer count clears in the cycle after `timer_start`. The short expiry appears when the count reaches `SHORT_CYCLES`, so a yellow phase lasts `SHORT_CYCLES`+2 cycles.
- R9: A farm car that waits the whole time never ends highway green early. Highway green lasts `LONG_CYCLES`+1 cycles after reset and `LONG_CYCLES`+2 cycles after farm yellow.
- R10: With a car present throughout, farm green is capped at `LONG_CYCLES`+2 cycles.
- R11: Farm green ends early, at the first cycle edge that samples `farm_car` low. If the car has already gone when farm green begins, farm green lasts one cycle.
- R12: The three state codings (`STATE_CODING` 0: 00/01/11/10, 1: 00/10/01/11, 2: one-hot 0001/0010/0100/1000 for highway green/yellow, farm green/yellow) give identical port behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| farm_car | input | 1 | Farm-road car sensor, 1 when a car waits |
| hw_lamp | output | 2 | Highway light colour code |
| farm_lamp | output | 2 | Farm-road light colour code |
| timer_start | output | 1 | Registered pulse that restarts the interval timer on each phase change |

## Verification
The bench builds three copies with `SHORT_CYCLES`=3 and `LONG_CYCLES`=8, one for each state coding, and compares all three with one behavioural model on every clock. These short limits let the bench reach many complete cycles of the crossing in a few hundred clocks. They also bring several corners within reach: the timer saturating during a long car-free highway green, a car arriving after the long expiry has already occurred, and farm green being entered with no car present.

// File: rtl/tl_pkg.sv
package tl_pkg;

  typedef enum logic [1:0] {
    PH_HG = 2'd0,
    PH_HY = 2'd1,
    PH_FG = 2'd2,
    PH_FY = 2'd3
  } phase_e;

  localparam logic [1:0] LAMP_GREEN  = 2'b00;
  localparam logic [1:0] LAMP_YELLOW = 2'b01;
  localparam logic [1:0] LAMP_RED    = 2'b10;

  localparam int CODING_SEQ    = 0;
  localparam int CODING_ALT    = 1;
  localparam int CODING_ONEHOT = 2;

  function automatic int code_width(input int coding);
    return (coding == CODING_ONEHOT) ? 4 : 2;
  endfunction

  // Phase to stored code, zero-extended to four bits
  function automatic logic [3:0] enc_phase(input int coding, input phase_e p);
    logic [3:0] r;
    case (coding)
      CODING_SEQ: begin
        case (p)
          PH_HG:   r = 4'b0000;
          PH_HY:   r = 4'b0001;
          PH_FG:   r = 4'b0011;
          default: r = 4'b0010;
        endcase
      end
      CODING_ALT: begin
        case (p)
          PH_HG:   r = 4'b0000;
          PH_HY:   r = 4'b0010;
          PH_FG:   r = 4'b0001;
          default: r = 4'b0011;
        endcase
      end
      default: r = 4'b0001 << p;
    endcase
    return r;
  endfunction

  // Stored code to phase; an unused code falls back to highway green
  function automatic phase_e dec_phase(input int coding, input logic [3:0] c);
    phase_e r;
    r = PH_HG;
    for (int i = 0; i < 4; i++) begin
      if (enc_phase(coding, phase_e'(i[1:0])) == c) r = phase_e'(i[1:0]);
    end
    return r;
  endfunction

endpackage

// File: rtl/tl_interval_timer.sv
module tl_interval_timer #(
  parameter int SHORT_CYCLES = 4,
  parameter int LONG_CYCLES  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic short_done,
  output logic long_done
);

  localparam int CW = $clog2(LONG_CYCLES + 1);
  localparam logic [CW-1:0] SHORT_V = CW'(SHORT_CYCLES);
  localparam logic [CW-1:0] LONG_V  = CW'(LONG_CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (restart) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (cnt_q < LONG_V) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // The count is stale in the restart cycle, so the flags are masked there
  assign short_done = !restart && (cnt_q >= SHORT_V);
  assign long_done  = !restart && (cnt_q >= LONG_V);

  // R8
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));

  // R8
  long_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (long_done && !restart) |=> (long_done || restart));

endmodule

// File: rtl/tl_phase_fsm.sv
module tl_phase_fsm
  import tl_pkg::*;
#(
  parameter int STATE_CODING = 0
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   farm_car,
  input  logic   short_done,
  input  logic   long_done,
  output phase_e phase,
  output logic   timer_start
);

  localparam int SW = code_width(STATE_CODING);
  localparam logic [3:0] RST_FULL = enc_phase(STATE_CODING, PH_HG);
  localparam logic [SW-1:0] RST_CODE = RST_FULL[SW-1:0];

  logic [SW-1:0] code_q, code_d;
  logic [3:0]    code_ext, nxt_full;
  logic          st_q, st_d;
  phase_e        cur_ph, nxt_ph;

  generate
    if (SW == 4) begin : g_wide
      assign code_ext = code_q;
    end else begin : g_narrow
      assign code_ext = {{(4-SW){1'b0}}, code_q};
    end
  endgenerate

  assign cur_ph = dec_phase(STATE_CODING, code_ext);

  always_comb begin
    nxt_ph = cur_ph;
    st_d   = 1'b0;
    case (cur_ph)
      PH_HG: if (long_done && farm_car) begin
        nxt_ph = PH_HY;
        st_d   = 1'b1;
      end
      PH_HY: if (short_done) begin
        nxt_ph = PH_FG;
        st_d   = 1'b1;
      end
      PH_FG: if (long_done || !farm_car) begin
        nxt_ph = PH_FY;
        st_d   = 1'b1;
      end
      default: if (short_done) begin
        nxt_ph = PH_HG;
        st_d   = 1'b1;
      end
    endcase
  end

  assign nxt_full = enc_phase(STATE_CODING, nxt_ph);
  assign code_d   = nxt_full[SW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= RST_CODE;
      st_q   <= 1'b0;
    end else begin
      code_q <= code_d;
      st_q   <= st_d;
    end
  end

  assign phase       = cur_ph;
  assign timer_start = st_q;

  // R2
  hg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HG && !(long_done && farm_car)) |=> (phase == PH_HG));

  // R3
  hy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HY && !short_done) |=> (phase == PH_HY));

  // R6
  start_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(phase) |-> timer_start);

  // R10
  fg_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FG && long_done) |=> (phase == PH_FY));

endmodule

// File: rtl/tl_lamp_map.sv
module tl_lamp_map
  import tl_pkg::*;
(
  input  phase_e     phase,
  output logic [1:0] hw_lamp,
  output logic [1:0] farm_lamp
);

  always_comb begin
    case (phase)
      PH_HG: begin
        hw_lamp   = LAMP_GREEN;
        farm_lamp = LAMP_RED;
      end
      PH_HY: begin
        hw_lamp   = LAMP_YELLOW;
        farm_lamp = LAMP_RED;
      end
      PH_FG: begin
        hw_lamp   = LAMP_RED;
        farm_lamp = LAMP_GREEN;
      end
      default: begin
        hw_lamp   = LAMP_RED;
        farm_lamp = LAMP_YELLOW;
      end
    endcase
  end

endmodule

// File: rtl/tl_crossing_ctrl.sv
module tl_crossing_ctrl
  import tl_pkg::*;
#(
  parameter int SHORT_CYCLES = 4,
  parameter int LONG_CYCLES  = 16,
  parameter int STATE_CODING = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       farm_car,
  output logic [1:0] hw_lamp,
  output logic [1:0] farm_lamp,
  output logic       timer_start
);

  logic   short_done, long_done;
  phase_e phase;

  tl_interval_timer #(
    .SHORT_CYCLES(SHORT_CYCLES),
    .LONG_CYCLES (LONG_CYCLES)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (timer_start),
    .short_done(short_done),
    .long_done (long_done)
  );

  tl_phase_fsm #(
    .STATE_CODING(STATE_CODING)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .farm_car   (farm_car),
    .short_done (short_done),
    .long_done  (long_done),
    .phase      (phase),
    .timer_start(timer_start)
  );

  tl_lamp_map u_lamps (
    .phase    (phase),
    .hw_lamp  (hw_lamp),
    .farm_lamp(farm_lamp)
  );

  // R7
  one_red_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_lamp == LAMP_RED) || (farm_lamp == LAMP_RED));

endmodule

// File: tb/sim_tl_crossing_ctrl.sv
module sim_tl_crossing_ctrl;

  localparam int S = 3;
  localparam int L = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic farm_car = 1'b0;
  logic [2:0][1:0] hw_v, fr_v;
  logic [2:0]      st_v;

  always #5 clk = ~clk;

  tl_crossing_ctrl #(.SHORT_CYCLES(S), .LONG_CYCLES(L), .STATE_CODING(0)) u0 (
    .clk(clk), .rst_n(rst_n), .farm_car(farm_car),
    .hw_lamp(hw_v[0]), .farm_lamp(fr_v[0]), .timer_start(st_v[0]));
  tl_crossing_ctrl #(.SHORT_CYCLES(S), .LONG_CYCLES(L), .STATE_CODING(1)) u1 (
    .clk(clk), .rst_n(rst_n), .farm_car(farm_car),
    .hw_lamp(hw_v[1]), .farm_lamp(fr_v[1]), .timer_start(st_v[1]));
  tl_crossing_ctrl #(.SHORT_CYCLES(S), .LONG_CYCLES(L), .STATE_CODING(2)) u2 (
    .clk(clk), .rst_n(rst_n), .farm_car(farm_car),
    .hw_lamp(hw_v[2]), .farm_lamp(fr_v[2]), .timer_start(st_v[2]));

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // Behavioural reference: phase 0..3 = HG, HY, FG, FY
  int m_ph = 0;
  int m_cnt = 0;
  bit m_st = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_st = 0;
    end else begin
      bit ts, tl, nst;
      int nph;
      ts = !m_st && (m_cnt >= S);
      tl = !m_st && (m_cnt >= L);
      nph = m_ph; nst = 0;
      if (m_ph == 0 && tl && farm_car) begin nph = 1; nst = 1; end
      else if (m_ph == 1 && ts) begin nph = 2; nst = 1; end
      else if (m_ph == 2 && (tl || !farm_car)) begin nph = 3; nst = 1; end
      else if (m_ph == 3 && ts) begin nph = 0; nst = 1; end
      if (m_st) m_cnt = 0;
      else if (m_cnt < L) m_cnt = m_cnt + 1;
      m_ph = nph;
      m_st = nst;
    end
  end

  function automatic int exp_hw(input int ph);
    return (ph == 0) ? 0 : (ph == 1) ? 1 : 2;
  endfunction
  function automatic int exp_fr(input int ph);
    return (ph == 2) ? 0 : (ph == 3) ? 1 : 2;
  endfunction
  function automatic string ph_tag(input int ph);
    case (ph)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  // Per-cycle comparison of all three codings with the model (R12)
  always @(negedge clk) begin
    for (int k = 0; k < 3; k++) begin
      string tg;
      tg = !rst_n ? "R1" : ph_tag(m_ph);
      chk($sformatf("%s R7 R12 hw_lamp u%0d", tg, k), int'(hw_v[k]), exp_hw(m_ph));
      chk($sformatf("%s R7 R12 farm_lamp u%0d", tg, k), int'(fr_v[k]), exp_fr(m_ph));
      chk($sformatf("%s R6 R12 timer_start u%0d", !rst_n ? "R1" : "", k),
          int'(st_v[k]), int'(m_st));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      finish_run();
    end
  end

  // Counts negedges in the current lamp pair, returns at the first one of the next
  task automatic measure(input int limit, output int n);
    logic [3:0] p;
    p = {hw_v[0], fr_v[0]};
    n = 0;
    while ({hw_v[0], fr_v[0]} == p && n < limit) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    int n;
    farm_car = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    measure(1000, n); chk("R9 first highway green with car waiting", n, L + 1);
    measure(1000, n); chk("R8 R3 highway yellow length", n, S + 2);
    measure(1000, n); chk("R10 capped farm green", n, L + 2);
    measure(1000, n); chk("R5 farm yellow length", n, S + 2);
    measure(1000, n); chk("R9 highway green after farm yellow", n, L + 2);
    measure(1000, n); chk("R3 highway yellow again", n, S + 2);

    // Now in the first cycle of farm green; drop the car two cycles later
    repeat (2) @(negedge clk);
    chk("R11 farm still green before drop", int'(fr_v[0]), 0);
    farm_car = 1'b0;
    @(negedge clk);
    chk("R11 farm yellow right after car leaves", int'(fr_v[0]), 1);
    chk("R6 start pulse on early end", int'(st_v[0]), 1);
    measure(1000, n); chk("R5 farm yellow after early end", n, S + 2);

    // Highway green with no car: never yields
    measure(4 * L, n); chk("R2 highway green held without car", n, 4 * L);
    chk("R2 highway still green", int'(hw_v[0]), 0);

    // Car arrives after the long expiry: yields on the next edge
    farm_car = 1'b1;
    @(negedge clk);
    chk("R2 late car moves to yellow at once", int'(hw_v[0]), 1);
    chk("R6 start pulse on late car", int'(st_v[0]), 1);

    // Car leaves during yellow: farm green lasts one cycle
    farm_car = 1'b0;
    measure(1000, n); chk("R3 highway yellow with car gone", n, S + 2);
    measure(1000, n); chk("R11 farm green with no car", n, 1);
    measure(1000, n); chk("R5 farm yellow final", n, S + 2);
    repeat (5) @(negedge clk);
    chk("R2 back to highway green", int'(hw_v[0]), 0);

    finish_run();
  end

endmodule